// File: doc/BRIEF.md
# Half-Width Float Immediate to Double Expander

This block serves the floating-point load-immediate path of a scalar FP pipeline. It takes a 32-bit instruction word and pulls out the destination register index and a 16-bit immediate. The immediate is split across two fields that are not next to each other. The block treats the immediate as the upper half of an IEEE754 single-precision value, with the lower sixteen bits zero. It then widens that single to an IEEE754 double without any loss. The result, the register index and a write strobe come out of registers one clock after the instruction is presented.

The opcode check is a single match against parameterised major and extended opcode values. An instruction that does not match still travels through the datapath, but it raises no write. The widening is exact for every class of input. Zeros keep their sign. Normal values are rebiased. Subnormal single values are renormalised into normal doubles. Infinities and NaNs keep their sign and their fraction bits.

Top module: `bf16_imm_widen`

## Requirements
- R1: Instruction bits use LSB0 indices in this project. The immediate is formed as {insn[0], insn[20:6]}: bit 0 of the instruction is the immediate's most significant bit, and insn[20:6] are its low 15 bits. The single-precision value is {immediate, 16'h0000}.
- R2: The write index wr_idx is insn[25:21] of the captured instruction.
- R3: For a single exponent e with 0 < e < 255, the double exponent is e + 896. The 7 immediate fraction bits sit at double bits [51:45], and double bits [44:0] are zero. The sign is copied to bit 63.
- R4: Exponent 0 with fraction 0 gives a double whose bits [62:0] are zero and whose bit 63 is the immediate sign.
- R5: Exponent 0 with a nonzero fraction gives a normal double that is equal in value to the subnormal single. For example, immediate 0x0001 gives 2^-133, which is 0x37A0000000000000.
- R6: Exponent 255 gives double exponent 0x7FF. The sign is kept, and the fraction bits are placed at [51:45]. Infinities therefore stay infinities, and NaN payloads are kept.
- R7: The immediates 0x0000, 0x8000, 0x3F80, 0xBF80, 0xBFC0, 0x7FC0, 0x7F80, 0xFF80 and 0x3FFF give the following doubles, in that order: +0.0, -0.0, +1.0, -1.0, -1.5, +quiet NaN (0x7FF8000000000000), +Inf, -Inf and +1.9921875.
- R8: wr_en is high in the cycle after a clock edge that samples in_valid=1 together with a matching opcode. insn[31:26] must equal MAJOR_OP and insn[5:1] must equal EXT_OP. wr_en is high for exactly one cycle per such input.
- R9: wr_en stays low after an edge where either opcode field mismatches, even if in_valid is high.
- R10: A synchronous active-high reset clears wr_en, wr_idx and wr_data to zero.
- R11: While in_valid is low, wr_idx and wr_data hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| insn | input | 32 | Instruction word |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 5 | Destination FP register index |
| wr_data | output | 64 | Widened double-precision value |

## Verification
The design has one register stage, so every output is due exactly one edge after the stimulus that produced it. This covers wr_en, wr_idx and wr_data, and also the hold behaviour when in_valid is low. The bench drives each input on a falling edge. It reads the outputs on the next falling edge, which is half a period after the capturing rising edge, so the sample never lands on the edge itself. All 65536 immediates are swept back to back, with a different register index for each one. The expected double is computed with real arithmetic and exact power-of-two scaling. Zero, infinity and NaN bit patterns are built directly.

// File: rtl/bf16_imm_pkg.sv
package bf16_imm_pkg;
  localparam int INSN_W = 32;
  localparam int MAJ_W  = 6;
  localparam int IDX_W  = 5;
  localparam int XO_W   = 5;
  localparam int IMM_W  = 16;

  typedef struct packed {
    logic [MAJ_W-1:0] major;
    logic [IDX_W-1:0] dest;
    logic [XO_W-1:0]  xo;
    logic [IMM_W-1:0] imm;
  } imm_fields_t;
endpackage

// File: rtl/bf16_imm_decode.sv
module bf16_imm_decode
  import bf16_imm_pkg::*;
#(
  parameter logic [MAJ_W-1:0] MAJOR_OP = 6'd19,
  parameter logic [XO_W-1:0]  EXT_OP   = 5'd11
) (
  input  logic [INSN_W-1:0] insn,
  output imm_fields_t       fields,
  output logic              hit
);
  // LSB0 view: [31:26] major, [25:21] dest, [20:6] imm low, [5:1] xo, [0] imm top
  always_comb begin
    fields.major = insn[31:26];
    fields.dest  = insn[25:21];
    fields.xo    = insn[5:1];
    fields.imm   = {insn[0], insn[20:6]};
    hit          = (fields.major == MAJOR_OP) && (fields.xo == EXT_OP);
  end
endmodule

// File: rtl/bf16_imm_lzc.sv
module bf16_imm_lzc #(
  parameter int W  = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    logic found;
    found = 1'b0;
    count = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (vec[i]) found = 1'b1;
        else        count = count + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bf16_imm_fp_widen.sv
module bf16_imm_fp_widen #(
  parameter int SRC_EXP_W  = 8,
  parameter int SRC_FRAC_W = 23,
  parameter int DST_EXP_W  = 11,
  parameter int DST_FRAC_W = 52,
  localparam int SRC_W     = 1 + SRC_EXP_W + SRC_FRAC_W,
  localparam int DST_W     = 1 + DST_EXP_W + DST_FRAC_W
) (
  input  logic [SRC_W-1:0] src,
  output logic [DST_W-1:0] dst
);
  localparam int PAD        = DST_FRAC_W - SRC_FRAC_W;
  localparam int SRC_BIAS   = (1 << (SRC_EXP_W - 1)) - 1;
  localparam int DST_BIAS   = (1 << (DST_EXP_W - 1)) - 1;
  localparam int BIAS_SHIFT = DST_BIAS - SRC_BIAS;
  localparam int CW         = $clog2(SRC_FRAC_W + 1);

  logic                  sgn;
  logic [SRC_EXP_W-1:0]  s_exp;
  logic [SRC_FRAC_W-1:0] s_frac;
  logic [CW-1:0]         lz;
  logic [SRC_FRAC_W-1:0] s_shift;
  logic [SRC_FRAC_W-1:0] s_norm;
  logic [DST_EXP_W-1:0]  d_exp;
  logic [DST_FRAC_W-1:0] d_frac;

  assign sgn    = src[SRC_W-1];
  assign s_exp  = src[SRC_W-2 -: SRC_EXP_W];
  assign s_frac = src[SRC_FRAC_W-1:0];

  bf16_imm_lzc #(.W(SRC_FRAC_W)) u_lzc (
    .vec   (s_frac),
    .count (lz)
  );

  // drop the leading one after normalisation
  assign s_shift = s_frac << lz;
  assign s_norm  = {s_shift[SRC_FRAC_W-2:0], 1'b0};

  always_comb begin
    if (&s_exp) begin
      d_exp  = '1;
      d_frac = DST_FRAC_W'(s_frac) << PAD;
    end else if (s_exp == '0 && s_frac == '0) begin
      d_exp  = '0;
      d_frac = '0;
    end else if (s_exp == '0) begin
      d_exp  = DST_EXP_W'(BIAS_SHIFT) - DST_EXP_W'(lz);
      d_frac = DST_FRAC_W'(s_norm) << PAD;
    end else begin
      d_exp  = DST_EXP_W'(s_exp) + DST_EXP_W'(BIAS_SHIFT);
      d_frac = DST_FRAC_W'(s_frac) << PAD;
    end
  end

  assign dst = {sgn, d_exp, d_frac};

  always_comb begin
    p_special_kept_r6: assert (!(&s_exp) || (&d_exp));
    p_subnorm_normal_r5: assert (!(s_exp == '0 && s_frac != '0) ||
                                 (d_exp != '0 && !(&d_exp)));
    p_sign_kept_r3: assert (dst[DST_W-1] == src[SRC_W-1]);
  end
endmodule

// File: rtl/bf16_imm_widen.sv
module bf16_imm_widen
  import bf16_imm_pkg::*;
#(
  parameter logic [MAJ_W-1:0] MAJOR_OP = 6'd19,
  parameter logic [XO_W-1:0]  EXT_OP   = 5'd11,
  parameter int SGL_EXP_W  = 8,
  parameter int SGL_FRAC_W = 23,
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52,
  localparam int SGL_W     = 1 + SGL_EXP_W + SGL_FRAC_W,
  localparam int DBL_W     = 1 + DBL_EXP_W + DBL_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DBL_W-1:0]  wr_data
);
  localparam int LOW_PAD = SGL_W - IMM_W;

  imm_fields_t             fld;
  logic                    hit;
  logic [SGL_W-1:0]        sgl;
  logic [DBL_W-1:0]        dbl;

  bf16_imm_decode #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) u_dec (
    .insn   (insn),
    .fields (fld),
    .hit    (hit)
  );

  assign sgl = {fld.imm, {LOW_PAD{1'b0}}};

  bf16_imm_fp_widen #(
    .SRC_EXP_W (SGL_EXP_W),  .SRC_FRAC_W (SGL_FRAC_W),
    .DST_EXP_W (DBL_EXP_W),  .DST_FRAC_W (DBL_FRAC_W)
  ) u_widen (
    .src (sgl),
    .dst (dbl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= in_valid & hit;
      if (in_valid) begin
        wr_idx  <= fld.dest;
        wr_data <= dbl;
      end
    end
  end

  p_we_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && hit) |=> wr_en);
  p_no_we_mismatch_r9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && hit) |=> !wr_en);
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(wr_data) && $stable(wr_idx)));
  p_dest_idx_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (wr_idx == $past(insn[25:21])));
  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_en && wr_data == '0 && wr_idx == '0));
endmodule

// File: tb/bf16_imm_widen_tb.sv
`timescale 1ns/1ps
module bf16_imm_widen_tb;
  localparam logic [5:0] MAJ = 6'd19;
  localparam logic [4:0] XO  = 5'd11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bf16_imm_widen #(.MAJOR_OP(MAJ), .EXT_OP(XO)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [31:0] mk(input logic [5:0] mj, input logic [4:0] d,
                                     input logic [4:0] xo, input logic [15:0] imm);
    return {mj, d, imm[14:0], xo, imm[15]};
  endfunction

  function automatic logic [63:0] ref_dbl(input logic [15:0] imm);
    logic       s;
    logic [7:0] e;
    logic [6:0] f;
    real v;
    int  ex;
    s = imm[15]; e = imm[14:7]; f = imm[6:0];
    if (e == 8'hFF) return {s, 11'h7FF, f, 45'b0};
    if (e == 8'h00 && f == 7'h00) return {s, 63'b0};
    if (e == 8'h00) begin v = real'(f); ex = -133; end
    else begin v = real'(32'(f) + 128); ex = int'(e) - 134; end
    for (int k = 0; k < ex; k++) v = v * 2.0;
    for (int k = 0; k > ex; k--) v = v * 0.5;
    if (s) v = -v;
    return $realtobits(v);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [31:0] w);
    in_valid = v;
    insn = w;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] consts [9];
    logic [63:0] cvals  [9];
    logic [63:0] held;
    consts = '{16'h0000, 16'h8000, 16'h3F80, 16'hBF80, 16'hBFC0,
               16'h7FC0, 16'h7F80, 16'hFF80, 16'h3FFF};
    cvals  = '{64'h0000000000000000, 64'h8000000000000000, 64'h3FF0000000000000,
               64'hBFF0000000000000, 64'hBFF8000000000000, 64'h7FF8000000000000,
               64'h7FF0000000000000, 64'hFFF0000000000000, 64'h3FFFE00000000000};

    repeat (3) @(negedge clk);
    chk("R10 reset wr_en", 64'(wr_en), 64'd0);
    chk("R10 reset wr_data", wr_data, 64'd0);
    chk("R10 reset wr_idx", 64'(wr_idx), 64'd0);
    rst = 1'b0;

    // R7 named constants
    for (int i = 0; i < 9; i++) begin
      apply(1'b1, mk(MAJ, 5'(i + 3), XO, consts[i]));
      chk($sformatf("R7 const %h", consts[i]), wr_data, cvals[i]);
      chk("R8 wr_en after valid", 64'(wr_en), 64'd1);
    end

    // R5 explicit subnormal
    apply(1'b1, mk(MAJ, 5'd1, XO, 16'h0001));
    chk("R5 imm 0001", wr_data, 64'h37A0000000000000);

    // R8 single-cycle pulse, R11 hold
    held = wr_data;
    apply(1'b0, mk(MAJ, 5'd30, XO, 16'h4000));
    chk("R8 pulse ends", 64'(wr_en), 64'd0);
    chk("R11 data held", wr_data, held);
    chk("R11 idx held", 64'(wr_idx), 64'd1);

    // R9 mismatches
    apply(1'b1, mk(MAJ ^ 6'd1, 5'd7, XO, 16'h3F80));
    chk("R9 major mismatch", 64'(wr_en), 64'd0);
    apply(1'b1, mk(MAJ, 5'd7, XO ^ 5'd4, 16'h3F80));
    chk("R9 xo mismatch", 64'(wr_en), 64'd0);

    // R1 R2 R3 R4 R5 R6 exhaustive sweep
    for (int i = 0; i < 65536; i++) begin
      logic [15:0] imm;
      logic [4:0]  d;
      string tag;
      imm = 16'(i);
      d = imm[4:0] ^ imm[9:5] ^ 5'(imm[15:10]);
      apply(1'b1, mk(MAJ, d, XO, imm));
      if (imm[14:7] == 8'hFF) tag = "R6";
      else if (imm[14:7] == 8'h00 && imm[6:0] == 7'h00) tag = "R4";
      else if (imm[14:7] == 8'h00) tag = "R5";
      else tag = "R3";
      chk($sformatf("%s R1 imm %h data", tag, imm), wr_data, ref_dbl(imm));
      chk($sformatf("R2 imm %h idx", imm), 64'(wr_idx), 64'(d));
      if (!wr_en) chk("R8 sweep wr_en", 64'(wr_en), 64'd1);
    end

    apply(1'b0, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule